// File: doc/BRIEF.md
# Vectored Priority Interrupt Dispatcher

This block sits beside a processor's control state. It watches a set of interrupt request lines, drops the ones the current mask blocks, and picks the one with the lowest line index. It then reads that line's handle from a small vector table. A handle carries an entry-point address, a privilege mode bit and a fresh interrupt mask. In one clock edge the block loads all three into the live instruction pointer, mode and mask registers. It copies the values being replaced into save registers and places a handler parameter in a register of its own.

A software system-call request takes the same path through a reserved table entry placed after the hardware lines. Each dispatch raises a one-cycle take pulse. No further dispatch happens until the processor acknowledges. The processor updates the live context through a context write port, and it fills the vector table through a synchronous write port.

Top module: `irq_dispatch`

## Requirements
- R1: Among request lines that are high and unmasked, the lowest line index is dispatched, and vec_o reports that index.
- R2: A mask bit of 1 blocks the matching request line. When every high line is masked and no system call is requested, no dispatch occurs.
- R3: On dispatch, ip_o, mode_o and mask_o take the address, mode and mask of the table entry at the selected index. They are visible from the cycle after the dispatching clock edge.
- R4: On dispatch, sav_ip_o, sav_mode_o and sav_mask_o take the ip, mode and mask values held just before that dispatch.
- R5: On dispatch, param_o takes the line index, zero-extended, for a hardware request, or sys_arg_i for a system call.
- R6: A system call uses table entry N_IRQ (8 by default) and sets sys_o to 1. The mask does not block it. Any unmasked pending hardware request takes precedence over it, and sys_o is 0 for a hardware dispatch.
- R7: While en_i is low, nothing is dispatched.
- R8: take_o is high for exactly the one cycle after a dispatching edge. After a dispatch, no new dispatch occurs until ack_i has been high at a clock edge.
- R9: ctx_we_i loads ctx_ip_i, ctx_mode_i and ctx_mask_i into the live registers at the clock edge. If a dispatch happens at the same edge, the dispatch wins and the context write is dropped.
- R10: After reset, ip_o is 0, mode_o is 1 (supervisor), mask_o is all ones, take_o is 0 and every table entry is zero.
- R11: A table write with tbl_we_i stores into entry tbl_idx_i at the clock edge and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global dispatch enable |
| irq_i | input | N_IRQ | Level request lines, index 0 highest priority |
| sys_req_i | input | 1 | System-call request |
| sys_arg_i | input | PARAM_W | System-call parameter |
| ack_i | input | 1 | Acknowledge of the last dispatch |
| ctx_we_i | input | 1 | Live context write enable |
| ctx_ip_i | input | ADDR_W | Context instruction pointer |
| ctx_mode_i | input | 1 | Context mode, 1 = supervisor |
| ctx_mask_i | input | N_IRQ | Context interrupt mask |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_idx_i | input | IDX_W | Table entry index, 0..N_IRQ |
| tbl_ip_i | input | ADDR_W | Handle entry address |
| tbl_mode_i | input | 1 | Handle mode |
| tbl_mask_i | input | N_IRQ | Handle mask |
| ip_o | output | ADDR_W | Live instruction pointer |
| mode_o | output | 1 | Live mode, 1 = supervisor |
| mask_o | output | N_IRQ | Live interrupt mask |
| sav_ip_o | output | ADDR_W | Saved instruction pointer |
| sav_mode_o | output | 1 | Saved mode |
| sav_mask_o | output | N_IRQ | Saved mask |
| param_o | output | PARAM_W | Handler parameter |
| vec_o | output | IDX_W | Index of last dispatched entry |
| sys_o | output | 1 | Last dispatch was a system call |
| take_o | output | 1 | One-cycle dispatch pulse |

## Verification
The main function is tried with a single high line and with several lines high together, so a wrong priority order shows as a wrong index. Mask patterns that block the best candidate, and patterns that block every line, separate a mask applied before selection from one applied after it. System calls are raised alone, together with an unmasked hardware line, and under a full mask, which separates correct arbitration from plain mask gating. Dispatch is also attempted while the enable is low, while a previous dispatch is unacknowledged, and in the same cycle as a context write, to confirm the gating and the write precedence.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  typedef enum logic {
    MODE_USER  = 1'b0,
    MODE_SUPER = 1'b1
  } mode_e;

  localparam mode_e RESET_MODE = MODE_SUPER;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // descending scan: last hit is the lowest index
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int DEPTH  = 9,
  parameter int IW     = 4,
  parameter int ADDR_W = 16,
  parameter int MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [ADDR_W-1:0] wip_i,
  input  logic              wmode_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic [IW-1:0]     ridx_i,
  output logic [ADDR_W-1:0] rip_o,
  output logic              rmode_o,
  output logic [MASK_W-1:0] rmask_o
);
  logic [ADDR_W-1:0] ip_q   [DEPTH];
  logic              mode_q [DEPTH];
  logic [MASK_W-1:0] mask_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ip_q[g]   <= '0;
        mode_q[g] <= 1'b0;
        mask_q[g] <= '0;
      end else if (we_i && (widx_i == IW'(g))) begin
        ip_q[g]   <= wip_i;
        mode_q[g] <= wmode_i;
        mask_q[g] <= wmask_i;
      end
    end
  end

  always_comb begin
    rip_o   = '0;
    rmode_o = 1'b0;
    rmask_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx_i == IW'(i)) begin
        rip_o   = ip_q[i];
        rmode_o = mode_q[i];
        rmask_o = mask_q[i];
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int N_IRQ   = 8,
  parameter int ADDR_W  = 16,
  parameter int PARAM_W = 8,
  localparam int IDX_W  = $clog2(N_IRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               sys_req_i,
  input  logic [PARAM_W-1:0] sys_arg_i,
  input  logic               ack_i,
  input  logic               ctx_we_i,
  input  logic [ADDR_W-1:0]  ctx_ip_i,
  input  logic               ctx_mode_i,
  input  logic [N_IRQ-1:0]   ctx_mask_i,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [ADDR_W-1:0]  tbl_ip_i,
  input  logic               tbl_mode_i,
  input  logic [N_IRQ-1:0]   tbl_mask_i,
  output logic [ADDR_W-1:0]  ip_o,
  output logic               mode_o,
  output logic [N_IRQ-1:0]   mask_o,
  output logic [ADDR_W-1:0]  sav_ip_o,
  output logic               sav_mode_o,
  output logic [N_IRQ-1:0]   sav_mask_o,
  output logic [PARAM_W-1:0] param_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic               sys_o,
  output logic               take_o
);
  localparam int DEPTH   = N_IRQ + 1;
  localparam int SYS_IDX = N_IRQ;

  logic [ADDR_W-1:0]  ip_q, sav_ip_q;
  mode_e              mode_q, sav_mode_q;
  logic [N_IRQ-1:0]   mask_q, sav_mask_q;
  logic [PARAM_W-1:0] param_q;
  logic [IDX_W-1:0]   vec_q;
  logic               sys_q, take_q, busy_q;

  logic [N_IRQ-1:0]   pend_eff;
  logic               hw_vld;
  logic [IDX_W-1:0]   hw_idx, sel_idx;
  logic               go;
  logic [ADDR_W-1:0]  h_ip;
  logic               h_mode;
  logic [N_IRQ-1:0]   h_mask;

  assign pend_eff = irq_i & ~mask_q;

  irq_prio_pick #(.N(N_IRQ), .IW(IDX_W)) u_pick (
    .req_i (pend_eff),
    .vld_o (hw_vld),
    .idx_o (hw_idx)
  );

  assign sel_idx = hw_vld ? hw_idx : IDX_W'(SYS_IDX);
  assign go      = en_i && !busy_q && (hw_vld || sys_req_i);

  irq_vec_table #(.DEPTH(DEPTH), .IW(IDX_W), .ADDR_W(ADDR_W), .MASK_W(N_IRQ)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .widx_i  (tbl_idx_i),
    .wip_i   (tbl_ip_i),
    .wmode_i (tbl_mode_i),
    .wmask_i (tbl_mask_i),
    .ridx_i  (sel_idx),
    .rip_o   (h_ip),
    .rmode_o (h_mode),
    .rmask_o (h_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q       <= '0;
      mode_q     <= RESET_MODE;
      mask_q     <= '1;
      sav_ip_q   <= '0;
      sav_mode_q <= RESET_MODE;
      sav_mask_q <= '1;
      param_q    <= '0;
      vec_q      <= '0;
      sys_q      <= 1'b0;
    end else if (go) begin
      // handle applied atomically; old context saved for return
      ip_q       <= h_ip;
      mode_q     <= mode_e'(h_mode);
      mask_q     <= h_mask;
      sav_ip_q   <= ip_q;
      sav_mode_q <= mode_q;
      sav_mask_q <= mask_q;
      param_q    <= hw_vld ? PARAM_W'(hw_idx) : sys_arg_i;
      vec_q      <= sel_idx;
      sys_q      <= !hw_vld;
    end else if (ctx_we_i) begin
      ip_q   <= ctx_ip_i;
      mode_q <= mode_e'(ctx_mode_i);
      mask_q <= ctx_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      take_q <= go;
      if (go)         busy_q <= 1'b1;
      else if (ack_i) busy_q <= 1'b0;
    end
  end

  assign ip_o       = ip_q;
  assign mode_o     = mode_q;
  assign mask_o     = mask_q;
  assign sav_ip_o   = sav_ip_q;
  assign sav_mode_o = sav_mode_q;
  assign sav_mask_o = sav_mask_q;
  assign param_o    = param_q;
  assign vec_o      = vec_q;
  assign sys_o      = sys_q;
  assign take_o     = take_q;

  AST_TAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o) else $error("take held"); // R8

  AST_NO_TAKE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !take_o) |=> !take_o) else $error("take while busy"); // R8

  AST_NO_TAKE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !take_o) else $error("take while disabled"); // R7

  AST_LINE_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !sys_o) |-> |($past(pend_eff) & (N_IRQ'(1) << vec_o)))
    else $error("masked line taken"); // R2

  AST_HIGHEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !sys_o) |-> (($past(pend_eff) & ((N_IRQ'(1) << vec_o) - N_IRQ'(1))) == '0))
    else $error("lower priority taken"); // R1

  AST_SYS_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && sys_o) |-> ($past(pend_eff) == '0)) else $error("syscall beat irq"); // R6

  AST_SAVE_IP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (sav_ip_o == $past(ip_q))) else $error("save ip wrong"); // R4
endmodule

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int PW = 8;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, sys_req = 1'b0, ack = 1'b0, ctx_we = 1'b0, tbl_we = 1'b0;
  logic [N-1:0] irq = '0, ctx_mask = '0, tbl_mask = '0;
  logic [PW-1:0] sys_arg = '0;
  logic [AW-1:0] ctx_ip = '0, tbl_ip = '0;
  logic ctx_mode = 1'b0, tbl_mode = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [AW-1:0] ip, sav_ip;
  logic mode, sav_mode, sys, take;
  logic [N-1:0] mask, sav_mask;
  logic [PW-1:0] param;
  logic [IW-1:0] vec;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .irq_i(irq), .sys_req_i(sys_req),
    .sys_arg_i(sys_arg), .ack_i(ack), .ctx_we_i(ctx_we), .ctx_ip_i(ctx_ip),
    .ctx_mode_i(ctx_mode), .ctx_mask_i(ctx_mask), .tbl_we_i(tbl_we),
    .tbl_idx_i(tbl_idx), .tbl_ip_i(tbl_ip), .tbl_mode_i(tbl_mode),
    .tbl_mask_i(tbl_mask), .ip_o(ip), .mode_o(mode), .mask_o(mask),
    .sav_ip_o(sav_ip), .sav_mode_o(sav_mode), .sav_mask_o(sav_mask),
    .param_o(param), .vec_o(vec), .sys_o(sys), .take_o(take)
  );

  function automatic logic [AW-1:0] e_ip(int i);   return AW'(16'h1000 + i * 16'h0111); endfunction
  function automatic logic          e_mode(int i); return i[0];                        endfunction
  function automatic logic [N-1:0]  e_mask(int i); return N'(8'hF0 ^ i);               endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(int i, logic [AW-1:0] a, logic m, logic [N-1:0] k);
    tbl_we = 1; tbl_idx = IW'(i); tbl_ip = a; tbl_mode = m; tbl_mask = k;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic set_ctx(logic [AW-1:0] a, logic m, logic [N-1:0] k);
    ctx_we = 1; ctx_ip = a; ctx_mode = m; ctx_mask = k;
    @(negedge clk);
    ctx_we = 0;
  endtask

  task automatic do_ack();
    irq = '0; sys_req = 0; ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  // drive a request, expect dispatch of entry idx one edge later
  task automatic expect_take(string req, logic [N-1:0] lines, logic s, logic [PW-1:0] arg,
                             logic [AW-1:0] oip, logic om, logic [N-1:0] ok,
                             int idx, logic [PW-1:0] eparam, logic esys);
    irq = lines; sys_req = s; sys_arg = arg;
    @(negedge clk);
    check({req, " take"}, 32'(take), 1);
    check({req, " vec R1"}, 32'(vec), 32'(idx));
    check({req, " ip R3"}, 32'(ip), 32'(e_ip(idx)));
    check({req, " mode R3"}, 32'(mode), 32'(e_mode(idx)));
    check({req, " mask R3"}, 32'(mask), 32'(e_mask(idx)));
    check({req, " sav R4"}, {sav_mask, 7'd0, sav_mode, sav_ip}, {ok, 7'd0, om, oip});
    check({req, " param R5"}, 32'(param), 32'(eparam));
    check({req, " sys R6"}, 32'(sys), 32'(esys));
    do_ack();
  endtask

  task automatic t_reset();
    check("R10 take", 32'(take), 0);
    check("R10 ip", 32'(ip), 0);
    check("R10 mode", 32'(mode), 1);
    check("R10 mask", 32'(mask), 32'(8'hFF));
  endtask

  task automatic t_empty_table();
    // R10: entries zero before any write
    set_ctx(16'h0042, 0, '0);
    irq = 8'h10;
    @(negedge clk);
    check("R10 zero entry ip", 32'(ip), 0);
    check("R10 zero entry mask", 32'(mask), 0);
    do_ack();
  endtask

  task automatic t_fill();
    for (int i = 0; i <= N; i++) wr_tbl(i, e_ip(i), e_mode(i), e_mask(i));
  endtask

  task automatic t_single();
    set_ctx(16'h0200, 0, '0);
    expect_take("R3 single", 8'h20, 0, 0, 16'h0200, 0, '0, 5, 5, 0);
  endtask

  task automatic t_multi();
    set_ctx(16'h0300, 1, '0);
    expect_take("R1 multi", 8'h6C, 0, 0, 16'h0300, 1, '0, 2, 2, 0);
    set_ctx(16'h0310, 0, '0);
    expect_take("R1 top", 8'h81, 0, 0, 16'h0310, 0, '0, 0, 0, 0);
  endtask

  task automatic t_mask();
    set_ctx(16'h0400, 0, 8'h01);
    expect_take("R2 partial", 8'h03, 0, 0, 16'h0400, 0, 8'h01, 1, 1, 0);
    set_ctx(16'h0410, 0, 8'h0F);
    irq = 8'h0F;
    repeat (3) @(negedge clk);
    check("R2 all masked", 32'(take), 0);
    check("R2 ip kept", 32'(ip), 32'(16'h0410));
    irq = '0;
  endtask

  task automatic t_enable();
    en = 0;
    set_ctx(16'h0500, 0, '0);
    irq = 8'h04; sys_req = 1;
    repeat (3) @(negedge clk);
    check("R7 disabled", 32'(take), 0);
    check("R7 ip kept", 32'(ip), 32'(16'h0500));
    irq = '0; sys_req = 0; en = 1;
  endtask

  task automatic t_busy();
    set_ctx(16'h0600, 0, '0);
    irq = 8'h08;
    @(negedge clk);
    check("R8 first take", 32'(take), 1);
    set_ctx(16'h0610, 0, '0);
    irq = 8'h01;
    @(negedge clk);
    check("R8 pulse low", 32'(take), 0);
    repeat (2) @(negedge clk);
    check("R8 held off", 32'(take), 0);
    check("R8 ip from ctx", 32'(ip), 32'(16'h0610));
    ack = 1;
    @(negedge clk);
    ack = 0;
    @(negedge clk);
    check("R8 after ack", 32'(take), 1);
    check("R8 after ack vec", 32'(vec), 0);
    do_ack();
  endtask

  task automatic t_sys();
    set_ctx(16'h0700, 0, '0);
    expect_take("R6 alone", '0, 1, 8'hA5, 16'h0700, 0, '0, N, 8'hA5, 1);
    set_ctx(16'h0710, 0, '0);
    expect_take("R6 irq first", 8'h40, 1, 8'h3C, 16'h0710, 0, '0, 6, 6, 0);
    set_ctx(16'h0720, 1, 8'hFF);
    expect_take("R6 mask ignored", 8'hFF, 1, 8'h5A, 16'h0720, 1, 8'hFF, N, 8'h5A, 1);
  endtask

  task automatic t_ctx_race();
    set_ctx(16'h0800, 0, '0);
    irq = 8'h02; ctx_we = 1; ctx_ip = 16'hBEEF; ctx_mode = 1; ctx_mask = 8'h55;
    @(negedge clk);
    ctx_we = 0;
    check("R9 dispatch wins ip", 32'(ip), 32'(e_ip(1)));
    check("R9 dispatch wins mask", 32'(mask), 32'(e_mask(1)));
    check("R9 save prior", 32'(sav_ip), 32'(16'h0800));
    do_ack();
    set_ctx(16'h0820, 1, 8'h33);
    check("R9 ctx write", {mask, 7'd0, mode, ip}, {8'h33, 7'd0, 1'b1, 16'h0820});
  endtask

  task automatic t_rewrite();
    wr_tbl(3, 16'hCAFE, 1, 8'h0A);
    set_ctx(16'h0900, 0, '0);
    irq = 8'h08;
    @(negedge clk);
    check("R11 new entry ip", 32'(ip), 32'(16'hCAFE));
    check("R11 new entry mask", 32'(mask), 32'(8'h0A));
    do_ack();
    set_ctx(16'h0910, 0, '0);
    expect_take("R11 neighbour", 8'h10, 0, 0, 16'h0910, 0, '0, 4, 4, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    en = 1;
    t_empty_table();
    t_fill();
    t_single();
    t_multi();
    t_mask();
    t_enable();
    t_busy();
    t_sys();
    t_ctx_race();
    t_rewrite();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule